// File: doc/BRIEF.md
# SCSI Phase-Following Transfer Engine

This block takes over the initiator side of a SCSI connection once a target has been selected. It moves bytes with the asynchronous REQ/ACK handshake and follows whatever information-transfer phase the target drives on its MSG, C/D and I/O lines. Each phase has its own buffer pointer in a small table. When the phase changes, the engine stores the advanced pointer of the phase it is leaving and continues with the stored pointer of the phase the target chose.

Software fills the pointer table through a load port while the engine is idle, then pulses `start`. Inbound bytes go to a byte-wide memory port, and outbound bytes come from it. The transfer ends when the target releases BSY, when a phase has no usable pointer, or when the handshake stops making progress for a configurable number of cycles. At the end the engine pulses `done_o`, holds a result code and releases the bus. The advanced pointers can then be read back.

Top module: `scsi_phase_engine`

## Requirements
- R1: After reset, ACK is low, the data drivers are off, `done_o` is low, `result_o` is 0 and no memory write is issued.
- R2: While the engine is idle, a cycle with `ptr_ld_i` high stores `ptr_wdata_i` in the table entry chosen by `ptr_sel_i`, and `ptr_rdata_o` shows that entry. A load attempted while a transfer runs leaves the table unchanged.
- R3: The bus phase code is {MSG, C/D, I/O}: 0 data-out, 1 data-in, 2 command, 3 status, 6 message-out, 7 message-in. Bit 0 (I/O) high means inbound. On the first REQ of a new phase, the engine loads that phase's pointer before it acknowledges anything.
- R4: In an inbound phase the drivers stay off and the byte on the data lines is written to memory at the current pointer. ACK then rises on the following cycle and stays high until REQ falls. On ACK's fall the pointer advances by one.
- R5: In an outbound phase the drivers are on and `data_o` carries the memory byte at the current pointer. That byte stays stable while ACK is high.
- R6: On a phase change and at the end of a transfer, the advanced pointer of the phase being left is written back to its table entry. After the transfer, each entry reads its start value plus the number of bytes moved in that phase.
- R7: If the new phase's entry is zero, or the code is 4 or 5 (no entry), the transfer ends with result 4 (bad phase) and no ACK is given.
- R8: When BSY falls after at least one message-in byte has moved, the result is 1 (OK).
- R9: When BSY falls with no message-in byte moved, the result is 2 (busy error).
- R10: After WDOG_CYCLES cycles with no handshake progress, the transfer ends with result 5 (timeout). This result takes priority over every other end condition, including a received message.
- R11: The end of a transfer gives a single-cycle `done_o` pulse. In that same cycle ACK and the drivers are released. `result_o` holds its value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| bsy_i | input | 1 | Target BSY |
| req_i | input | 1 | Target REQ |
| msg_i | input | 1 | Target MSG line (phase code bit 2) |
| cd_i | input | 1 | Target C/D line (phase code bit 1) |
| io_i | input | 1 | Target I/O line (phase code bit 0) |
| data_i | input | 8 | Data lines as seen by the initiator |
| ack_o | output | 1 | Initiator ACK |
| data_o | output | 8 | Outbound data byte |
| data_oe_o | output | 1 | Data driver enable |
| mem_addr_o | output | AW | Buffer memory address (current pointer) |
| mem_wdata_o | output | 8 | Byte to write to memory |
| mem_rdata_i | input | 8 | Byte read from memory at `mem_addr_o` (combinational) |
| mem_we_o | output | 1 | Memory write enable |
| ptr_ld_i | input | 1 | Pointer table load strobe |
| ptr_sel_i | input | 3 | Pointer table entry (phase code) for load and readback |
| ptr_wdata_i | input | AW | Pointer value to load |
| ptr_rdata_o | output | AW | Pointer table entry selected by `ptr_sel_i` |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| result_o | output | 3 | 0 none, 1 OK, 2 busy error, 4 bad phase, 5 timeout |

## Verification
When REQ is seen with a new phase, the pointer loads on the next edge. ACK rises one edge after a matching REQ is sampled and falls one edge after REQ's release. The bench therefore raises REQ at a falling edge and then polls ACK at later falling edges within a bounded window. An end condition sampled at an edge gives `done_o` and the result after that same edge. The bench checks that a BSY release shows `done_o` exactly one falling edge later. A transfer started with REQ never asserted must end exactly WDOG_CYCLES+1 falling edges after `start` drops. Read-back pointers and written memory bytes are compared after `done_o`, against sums computed from the byte counts of each sweep case.

// File: rtl/scsi_pe_pkg.sv
package scsi_pe_pkg;
  localparam int NPH = 8;  // size of the 3-bit phase code space

  localparam logic [2:0] PH_DOUT = 3'd0;
  localparam logic [2:0] PH_DIN  = 3'd1;
  localparam logic [2:0] PH_CMD  = 3'd2;
  localparam logic [2:0] PH_STAT = 3'd3;
  localparam logic [2:0] PH_MOUT = 3'd6;
  localparam logic [2:0] PH_MIN  = 3'd7;

  localparam logic [2:0] RES_NONE = 3'd0;
  localparam logic [2:0] RES_OK   = 3'd1;
  localparam logic [2:0] RES_BSY  = 3'd2;
  localparam logic [2:0] RES_BAD  = 3'd4;
  localparam logic [2:0] RES_TMO  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } pe_state_t;

  function automatic logic ph_has_ptr(input logic [2:0] p);
    return !(p == 3'd4 || p == 3'd5);
  endfunction
endpackage

// File: rtl/scsi_pe_ptr_table.sv
module scsi_pe_ptr_table
  import scsi_pe_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [2:0]    ld_idx,
  input  logic [AW-1:0] ld_val,
  input  logic          sv_en,
  input  logic [2:0]    sv_idx,
  input  logic [AW-1:0] sv_val,
  input  logic [2:0]    rd_a_idx,
  output logic [AW-1:0] rd_a,
  input  logic [2:0]    rd_b_idx,
  output logic [AW-1:0] rd_b,
  output logic [AW-1:0] min_ptr
);
  logic [AW-1:0] ent [NPH];

  for (genvar g = 0; g < NPH; g++) begin : g_ent
    if (ph_has_ptr(3'(g))) begin : g_reg
      logic [AW-1:0] r;
      logic          wr_sv, wr_ld;
      assign wr_sv = sv_en && (sv_idx == 3'(g));
      assign wr_ld = ld_en && (ld_idx == 3'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     r <= '0;
        else if (wr_sv) r <= sv_val;
        else if (wr_ld) r <= ld_val;
      end
      assign ent[g] = r;
    end else begin : g_none
      assign ent[g] = '0;
    end
  end

  assign rd_a    = ent[rd_a_idx];
  assign rd_b    = ent[rd_b_idx];
  assign min_ptr = ent[PH_MIN];
endmodule

// File: rtl/scsi_pe_wdog.sv
module scsi_pe_wdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scsi_pe_ctrl.sv
module scsi_pe_ctrl
  import scsi_pe_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bsy,
  input  logic          req,
  input  logic [2:0]    bus_ph,
  input  logic [7:0]    data_i,
  input  logic [7:0]    mem_rdata,
  input  logic          wd_exp,
  input  logic [AW-1:0] tbl_new,
  input  logic [AW-1:0] tbl_min,
  output logic          ack,
  output logic [7:0]    data_o,
  output logic          data_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          sv_en,
  output logic [2:0]    sv_idx,
  output logic [AW-1:0] sv_val,
  output logic          wd_clr,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result
);
  pe_state_t     st_q, st_d;
  logic [2:0]    ph_q, ph_d;
  logic          vld_q, vld_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          msg_q, msg_d;
  logic          done_q, done_d;
  logic [2:0]    res_q, res_d;
  logic          msg_now, fin;
  logic [2:0]    fin_res;

  // message-in counts as received once its pointer has moved off the start value
  assign msg_now = msg_q || (vld_q && ph_q == PH_MIN && ptr_q != tbl_min);

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    vld_d   = vld_q;
    ptr_d   = ptr_q;
    msg_d   = msg_q;
    res_d   = res_q;
    done_d  = 1'b0;
    sv_en   = 1'b0;
    mem_we  = 1'b0;
    wd_clr  = 1'b0;
    fin     = 1'b0;
    fin_res = RES_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_WAIT;
          vld_d  = 1'b0;
          msg_d  = 1'b0;
          res_d  = RES_NONE;
          wd_clr = 1'b1;
        end
      end
      default: begin
        if (wd_exp) begin
          fin     = 1'b1;
          fin_res = RES_TMO;
        end else if (!bsy) begin
          fin     = 1'b1;
          fin_res = msg_now ? RES_OK : RES_BSY;
        end else if (st_q == ST_WAIT && req) begin
          wd_clr = 1'b1;
          if (!vld_q || bus_ph != ph_q) begin
            sv_en = vld_q;
            msg_d = msg_now;
            if (tbl_new == '0) begin
              fin     = 1'b1;
              fin_res = RES_BAD;
            end else begin
              ph_d  = bus_ph;
              ptr_d = tbl_new;
              vld_d = 1'b1;
            end
          end else begin
            mem_we = ph_q[0];
            st_d   = ST_ACK;
          end
        end else if (st_q == ST_ACK && !req) begin
          wd_clr = 1'b1;
          st_d   = ST_WAIT;
          ptr_d  = ptr_q + 1'b1;
        end
        if (fin) begin
          st_d   = ST_IDLE;
          sv_en  = vld_q;
          vld_d  = 1'b0;
          done_d = 1'b1;
          res_d  = fin_res;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      vld_q  <= 1'b0;
      ptr_q  <= '0;
      msg_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= RES_NONE;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      vld_q  <= vld_d;
      ptr_q  <= ptr_d;
      msg_q  <= msg_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign sv_idx    = ph_q;
  assign sv_val    = ptr_q;
  assign busy      = (st_q != ST_IDLE);
  assign ack       = (st_q == ST_ACK);
  assign data_oe   = busy && vld_q && !ph_q[0];
  assign data_o    = data_oe ? mem_rdata : 8'h00;
  assign mem_addr  = ptr_q;
  assign mem_wdata = data_i;
  assign done      = done_q;
  assign result    = res_q;
endmodule

// File: rtl/scsi_phase_engine.sv
module scsi_phase_engine
  import scsi_pe_pkg::*;
#(
  parameter int AW          = 32,
  parameter int WDOG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bsy_i,
  input  logic          req_i,
  input  logic          msg_i,
  input  logic          cd_i,
  input  logic          io_i,
  input  logic [7:0]    data_i,
  output logic          ack_o,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          mem_we_o,
  input  logic          ptr_ld_i,
  input  logic [2:0]    ptr_sel_i,
  input  logic [AW-1:0] ptr_wdata_i,
  output logic [AW-1:0] ptr_rdata_o,
  output logic          done_o,
  output logic [2:0]    result_o
);
  logic [2:0]    bus_ph;
  logic          busy, wd_clr, wd_exp, sv_en, ld_en;
  logic [2:0]    sv_idx;
  logic [AW-1:0] sv_val, tbl_new, tbl_min;

  assign bus_ph = {msg_i, cd_i, io_i};
  assign ld_en  = ptr_ld_i && !busy;

  scsi_pe_ptr_table #(.AW(AW)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_idx   (ptr_sel_i),
    .ld_val   (ptr_wdata_i),
    .sv_en    (sv_en),
    .sv_idx   (sv_idx),
    .sv_val   (sv_val),
    .rd_a_idx (bus_ph),
    .rd_a     (tbl_new),
    .rd_b_idx (ptr_sel_i),
    .rd_b     (ptr_rdata_o),
    .min_ptr  (tbl_min)
  );

  scsi_pe_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wd_clr),
    .en      (busy),
    .expired (wd_exp)
  );

  scsi_pe_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bsy       (bsy_i),
    .req       (req_i),
    .bus_ph    (bus_ph),
    .data_i    (data_i),
    .mem_rdata (mem_rdata_i),
    .wd_exp    (wd_exp),
    .tbl_new   (tbl_new),
    .tbl_min   (tbl_min),
    .ack       (ack_o),
    .data_o    (data_o),
    .data_oe   (data_oe_o),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .mem_we    (mem_we_o),
    .sv_en     (sv_en),
    .sv_idx    (sv_idx),
    .sv_val    (sv_val),
    .wd_clr    (wd_clr),
    .busy      (busy),
    .done      (done_o),
    .result    (result_o)
  );
endmodule

// File: rtl/scsi_phase_engine_chk.sv
module scsi_phase_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       io_i,
  input logic       ack_o,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       mem_we_o,
  input logic       done_o,
  input logic [2:0] result_o
);
  // R4
  we_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> ack_o);

  // R4
  we_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !data_oe_o);

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && !done_o) |-> !$past(req_i));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(ack_o) && data_oe_o) |-> $stable(data_o));

  // R3
  drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> !$past(io_i));

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ack_o && !data_oe_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == 3'd1 || result_o == 3'd2 || result_o == 3'd4 || result_o == 3'd5));
endmodule

bind scsi_phase_engine scsi_phase_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .io_i      (io_i),
  .ack_o     (ack_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .mem_we_o  (mem_we_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/scsi_phase_engine_bench.sv
`timescale 1ns/1ps
module scsi_phase_engine_bench;
  localparam int AW   = 32;
  localparam int WDOG = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bsy_i = 1'b1;
  logic          req_i = 1'b0;
  logic          msg_i = 1'b0, cd_i = 1'b0, io_i = 1'b0;
  logic [7:0]    data_i = 8'h00;
  logic          ack_o, data_oe_o, mem_we_o, done_o;
  logic [7:0]    data_o, mem_wdata_o, mem_rdata_i;
  logic [AW-1:0] mem_addr_o, ptr_rdata_o;
  logic          ptr_ld_i = 1'b0;
  logic [2:0]    ptr_sel_i = 3'd0;
  logic [AW-1:0] ptr_wdata_i = '0;
  logic [2:0]    result_o;

  logic [7:0]    wr_mem [256];
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  assign mem_rdata_i = mem_addr_o[7:0] ^ 8'h5A;
  always @(posedge clk) if (mem_we_o) wr_mem[mem_addr_o[7:0]] <= mem_wdata_o;

  scsi_phase_engine #(.AW(AW), .WDOG_CYCLES(WDOG)) u_scsi_phase_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .bsy_i(bsy_i), .req_i(req_i),
    .msg_i(msg_i), .cd_i(cd_i), .io_i(io_i), .data_i(data_i),
    .ack_o(ack_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_we_o(mem_we_o), .ptr_ld_i(ptr_ld_i), .ptr_sel_i(ptr_sel_i),
    .ptr_wdata_i(ptr_wdata_i), .ptr_rdata_o(ptr_rdata_o),
    .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load_ptr(input logic [2:0] idx, input logic [AW-1:0] val);
    @(negedge clk);
    ptr_ld_i = 1'b1; ptr_sel_i = idx; ptr_wdata_i = val;
    @(negedge clk);
    ptr_ld_i = 1'b0;
  endtask

  task automatic read_ptr(input logic [2:0] idx, output logic [AW-1:0] val);
    @(negedge clk);
    ptr_sel_i = idx;
    #1 val = ptr_rdata_o;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // one target-side byte; for outbound phases the driven byte is compared with exp
  task automatic tgt_byte(input logic [2:0] ph, input logic [7:0] din, input logic [7:0] exp, input string tag);
    int w;
    @(negedge clk);
    {msg_i, cd_i, io_i} = ph; data_i = din; req_i = 1'b1;
    w = 0;
    while (!ack_o && w < 20) begin @(negedge clk); w++; end
    check(ack_o, {tag, " ack rise"}, ack_o, 1);
    if (!ph[0]) check(data_oe_o && data_o == exp, {tag, " outbound byte"}, {data_oe_o, data_o}, {1'b1, exp});
    else        check(!data_oe_o, {tag, " inbound drivers off"}, data_oe_o, 0);
    req_i = 1'b0;
    w = 0;
    while (ack_o && w < 20) begin @(negedge clk); w++; end
    check(!ack_o, {tag, " ack fall"}, ack_o, 0);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 500) begin @(negedge clk); cyc++; end
  endtask

  task automatic load_all();
    load_ptr(3'd0, 32'h60);
    load_ptr(3'd1, 32'h40);
    load_ptr(3'd2, 32'h10);
    load_ptr(3'd3, 32'h80);
    load_ptr(3'd6, 32'hC0);
    load_ptr(3'd7, 32'hA0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] v;
    int            cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!ack_o && !data_oe_o && !done_o && result_o == 3'd0 && !mem_we_o, "R1 reset outputs",
          {ack_o, data_oe_o, done_o, result_o, mem_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ack_o && !done_o && result_o == 3'd0, "R1 after release", {ack_o, done_o, result_o}, 0);

    // R2 load and readback
    load_ptr(3'd3, 32'hDEAD_BEE0);
    read_ptr(3'd3, v);
    check(v == 32'hDEAD_BEE0, "R2 readback", v, 32'hDEAD_BEE0);
    read_ptr(3'd4, v);
    check(v == 0, "R3 code 4 has no entry", v, 0);

    // sweep over byte counts per phase
    for (int nc = 1; nc <= 3; nc++) begin
      for (int ni = 0; ni <= 3; ni++) begin
        for (int nm = 0; nm <= 2; nm++) begin
          int run;
          run = nc * 16 + ni * 4 + nm;
          load_all();
          bsy_i = 1'b1;
          go();
          for (int k = 0; k < nc; k++)
            tgt_byte(3'd2, 8'h00, 8'((32'h10 + k) ^ 32'h5A), "R5 command");
          // attempted load while active must be ignored (R2)
          @(negedge clk); ptr_ld_i = 1'b1; ptr_sel_i = 3'd6; ptr_wdata_i = 32'h1234;
          @(negedge clk); ptr_ld_i = 1'b0;
          for (int k = 0; k < ni; k++)
            tgt_byte(3'd1, 8'(run * 7 + k), 8'h00, "R4 data-in");
          tgt_byte(3'd3, 8'(run + 8'h33), 8'h00, "R4 status");
          for (int k = 0; k < nm; k++)
            tgt_byte(3'd7, 8'(run + 8'h90 + k), 8'h00, "R4 msg-in");
          @(negedge clk); bsy_i = 1'b0;
          wait_done(cyc);
          check(cyc == 1, "R11 done one cycle after BSY loss", cyc, 1);
          check(!ack_o && !data_oe_o, "R11 bus released", {ack_o, data_oe_o}, 0);
          if (nm > 0) check(result_o == 3'd1, "R8 ok result", result_o, 1);
          else        check(result_o == 3'd2, "R9 busy error", result_o, 2);
          @(negedge clk);
          check(!done_o, "R11 done is a pulse", done_o, 0);
          bsy_i = 1'b1;
          repeat (2) @(negedge clk);
          check(result_o == (nm > 0 ? 3'd1 : 3'd2), "R11 result held", result_o, (nm > 0 ? 1 : 2));
          read_ptr(3'd2, v); check(v == 32'h10 + nc, "R6 command pointer", v, 32'h10 + nc);
          read_ptr(3'd1, v); check(v == 32'h40 + ni, "R6 data-in pointer", v, 32'h40 + ni);
          read_ptr(3'd3, v); check(v == 32'h81, "R6 status pointer", v, 32'h81);
          read_ptr(3'd7, v); check(v == 32'hA0 + nm, "R6 msg-in pointer", v, 32'hA0 + nm);
          read_ptr(3'd0, v); check(v == 32'h60, "R6 untouched data-out pointer", v, 32'h60);
          read_ptr(3'd6, v); check(v == 32'hC0, "R2 load during run ignored", v, 32'hC0);
          for (int k = 0; k < ni; k++)
            check(wr_mem[8'h40 + k] == 8'(run * 7 + k), "R4 data-in byte stored",
                  wr_mem[8'h40 + k], 8'(run * 7 + k));
          check(wr_mem[8'h80] == 8'(run + 8'h33), "R4 status byte stored", wr_mem[8'h80], 8'(run + 8'h33));
          for (int k = 0; k < nm; k++)
            check(wr_mem[8'hA0 + k] == 8'(run + 8'h90 + k), "R4 msg byte stored",
                  wr_mem[8'hA0 + k], 8'(run + 8'h90 + k));
        end
      end
    end

    // R7 zero pointer for data-out
    load_all();
    load_ptr(3'd0, 32'h0);
    go();
    tgt_byte(3'd2, 8'h00, 8'(32'h10 ^ 32'h5A), "R7 command first");
    @(negedge clk); {msg_i, cd_i, io_i} = 3'd0; req_i = 1'b1;
    wait_done(cyc);
    check(result_o == 3'd4, "R7 bad phase zero pointer", result_o, 4);
    check(!ack_o && !data_oe_o, "R7 no ack, drivers off", {ack_o, data_oe_o}, 0);
    req_i = 1'b0;
    read_ptr(3'd2, v); check(v == 32'h11, "R6 pointer saved before bad phase", v, 32'h11);

    // R7 undefined phase code 4
    load_all();
    go();
    @(negedge clk); {msg_i, cd_i, io_i} = 3'd4; req_i = 1'b1;
    wait_done(cyc);
    check(result_o == 3'd4, "R7 bad phase code 4", result_o, 4);
    req_i = 1'b0;

    // R10 timeout with no REQ: done exactly WDOG+1 falling edges after start drops
    load_all();
    go();
    wait_done(cyc);
    check(cyc == WDOG + 1, "R10 timeout latency", cyc, WDOG + 1);
    check(result_o == 3'd5, "R10 timeout result", result_o, 5);

    // R10 timeout wins over a received message when REQ hangs high
    load_all();
    go();
    tgt_byte(3'd7, 8'h77, 8'h00, "R10 msg-in first");
    @(negedge clk); {msg_i, cd_i, io_i} = 3'd7; req_i = 1'b1;
    wait_done(cyc);
    check(result_o == 3'd5, "R10 timeout priority", result_o, 5);
    check(!ack_o, "R11 ack dropped at timeout", ack_o, 0);
    req_i = 1'b0;
    read_ptr(3'd7, v); check(v == 32'hA1, "R6 msg pointer after timeout", v, 32'hA1);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule